// File: doc/BRIEF.md
# Four-Bank Interleaved Word Memory

This block is a backing store of 16-bit words, addressed in bytes and split into four banks that work independently. Each bank needs four cycles per access. A caller presents a byte address, write data and a read or a write strobe in one cycle. Bits [2:1] of the address choose the bank, so consecutive words land in different banks. A stream of requests that walks through consecutive words can therefore be accepted one per cycle.

A request is accepted in the cycle it is presented, unless its bank is still inside its four-cycle window. In that case the block raises `stall`, drops the request, and the caller presents it again later. A write updates storage at the end of its accepting cycle. Read data appears on `rdata` exactly two cycles after the read is accepted, and `rdata` is zero in every other cycle. The per-bank `busy` vector lets a caller pick a free bank before it issues a request. A malformed request raises `err` and has no effect: either both strobes are set, or an access uses an odd address.

The capacity is 2^`ADDR_W` bytes. A 64 KB instance sets `ADDR_W` to 16. The default is 12, which keeps the elaborated storage small. All contents are zero after reset.

Top module: `mbm_four_bank`

## Requirements
- R1: While reset is low, and in the first cycle after it, `rdata`, `busy`, `stall` and `err` are all zero, and any word that has not been written since reset reads back as zero. With no strobe high, `stall` and `err` stay low.
- R2: The bank of a request is address bits [2:1], read as an unsigned number 0 to 3. `busy[n]` belongs to bank n.
- R3: A read accepted in cycle k drives the stored word on `rdata` in cycle k+2. In every other cycle `rdata` is zero.
- R4: A write accepted in cycle k updates the addressed word at the end of cycle k. Any read accepted after cycle k returns the new value.
- R5: `busy[n]` is high in the cycle bank n accepts a request and in the three cycles that follow. Bank n accepts a new request in the fourth cycle after the accept, counting the accept cycle as cycle zero.
- R6: A request with a single strobe whose bank is busy from an earlier accept raises `stall` in that cycle. It is not performed: a stalled write leaves storage unchanged, and a stalled read produces no data.
- R7: A request to a free bank is accepted without stall in the cycle right after another bank accepted. Several banks can therefore be busy at once.
- R8: A request with both the read and the write strobe high raises `err` combinationally. It never raises `stall`, marks no bank busy, changes no storage and produces no read data.
- R9: A read or write whose address bit 0 is 1 raises `err`. It is ignored in the same way as in R8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W | Byte address of the request; bit 0 must be 0 |
| wdata | input | DATA_W | Word to store on a write |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| rdata | output | DATA_W | Read word in the data-valid cycle, zero otherwise |
| stall | output | 1 | Request refused because its bank is busy |
| busy | output | NUM_BANKS | Per-bank busy flags |
| err | output | 1 | Malformed request (both strobes, or odd address) |

## Verification
The bench builds the block with `ADDR_W` = 10, a 1 KB store with 128 words per bank, and keeps four banks, a four-cycle bank window and a two-cycle read latency. The small address space means that a long pseudo-random stream of reads and writes keeps hitting busy banks and keeps rereading words it wrote shortly before. Stall timing, back-to-back acceptance across banks and read-after-write ordering are all exercised many times. Bursts over consecutive words and probes of one bank in every cycle of its window pin down the edges of the window.

// File: rtl/mbm_pkg.sv
// Package: shared request classification for the banked word memory.
// Assumes: one request per cycle, at most one strobe meaningful.
package mbm_pkg;

    // Classification of the request presented in the current cycle
    typedef enum logic [1:0] {
        REQ_IDLE  = 2'd0,
        REQ_READ  = 2'd1,
        REQ_WRITE = 2'd2,
        REQ_BAD   = 2'd3
    } req_kind_e;

endpackage

// File: rtl/mbm_decode.sv
// Module: mbm_decode
// Splits a byte address into bank and row and classifies the request.
// Assumes: words are 2 bytes, bank bits sit just above the byte bit.
module mbm_decode
    import mbm_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int BANK_W = 2,
    localparam int ROW_W = ADDR_W - 1 - BANK_W
) (
    input  logic              rd,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    output req_kind_e         kind,
    output logic [BANK_W-1:0] bank,
    output logic [ROW_W-1:0]  row
);

    // Field extraction: bank from the bits above the byte bit, row above that
    always_comb begin
        bank = addr[BANK_W:1];
        row  = addr[ADDR_W-1:BANK_W+1];
    end

    // Request classification: both strobes or a misaligned access is bad
    always_comb begin
        if (!rd && !wr)             kind = REQ_IDLE;
        else if ((rd && wr) || addr[0]) kind = REQ_BAD;
        else if (rd)                kind = REQ_READ;
        else                        kind = REQ_WRITE;
    end

endmodule

// File: rtl/mbm_bank_timer.sv
// Module: mbm_bank_timer
// Tracks the occupancy window of one bank after it accepts a request.
// Assumes: take is only raised when busy_q is low; BANK_CYC >= 2.
module mbm_bank_timer #(
    parameter int BANK_CYC = 4,
    localparam int CNT_W = $clog2(BANK_CYC)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    output logic busy_q
);

    logic [CNT_W-1:0] remain_q;

    // Window counter: load the remaining busy cycles on accept, count down after
    always_ff @(posedge clk) begin
        if (!rst_n)
            remain_q <= '0;
        else if (take)
            remain_q <= CNT_W'(BANK_CYC - 1);
        else if (remain_q != '0)
            remain_q <= remain_q - 1'b1;
    end

    // Busy flag for the cycles after the accepting one
    always_comb busy_q = (remain_q != '0);

endmodule

// File: rtl/mbm_bank_store.sv
// Module: mbm_bank_store
// Word storage of one bank: synchronous write, combinational read.
// Assumes: reset is held long enough for the clear; write has priority over nothing else.
module mbm_bank_store #(
    parameter int DATA_W = 16,
    parameter int ROW_W  = 9,
    localparam int ROWS  = 1 << ROW_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ROW_W-1:0]  row,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rword
);

    logic [DATA_W-1:0] cells [ROWS];

    // Storage update: clear every row in reset, else commit an accepted write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ROWS; i++)
                cells[i] <= '0;
        end else if (we) begin
            cells[row] <= wdata;
        end
    end

    // Read port: current contents of the addressed row
    always_comb rword = cells[row];

endmodule

// File: rtl/mbm_rd_pipe.sv
// Module: mbm_rd_pipe
// Delays a captured read word by RD_LAT cycles; output is zero when no word is due.
// Assumes: RD_LAT >= 1, at most one launch per cycle.
module mbm_rd_pipe #(
    parameter int DATA_W = 16,
    parameter int RD_LAT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);

    logic              vld_q [RD_LAT];
    logic [DATA_W-1:0] dat_q [RD_LAT];

    // First stage: capture the word read in the accepting cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q[0] <= 1'b0;
            dat_q[0] <= '0;
        end else begin
            vld_q[0] <= launch;
            dat_q[0] <= launch ? din : '0;
        end
    end

    // Later stages: shift the captured word towards the output
    for (genvar s = 1; s < RD_LAT; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q[s] <= 1'b0;
                dat_q[s] <= '0;
            end else begin
                vld_q[s] <= vld_q[s-1];
                dat_q[s] <= dat_q[s-1];
            end
        end
    end

    // Output gating: only the due word is visible
    always_comb dout = vld_q[RD_LAT-1] ? dat_q[RD_LAT-1] : '0;

endmodule

// File: rtl/mbm_four_bank.sv
// Module: mbm_four_bank
// Interleaved word memory: NUM_BANKS banks, each occupied BANK_CYC cycles per access,
// reads returned RD_LAT cycles after acceptance, refused requests flagged by stall.
// Assumes: the caller retries stalled requests; bad requests are dropped with err.
module mbm_four_bank
    import mbm_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 16,
    parameter int NUM_BANKS = 4,
    parameter int BANK_CYC  = 4,
    parameter int RD_LAT    = 2,
    localparam int BANK_W   = $clog2(NUM_BANKS),
    localparam int ROW_W    = ADDR_W - 1 - BANK_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wdata,
    input  logic                 rd,
    input  logic                 wr,
    output logic [DATA_W-1:0]    rdata,
    output logic                 stall,
    output logic [NUM_BANKS-1:0] busy,
    output logic                 err
);

    req_kind_e             kind;
    logic [BANK_W-1:0]     bank;
    logic [ROW_W-1:0]      row;
    logic                  req_ok;
    logic                  accept;
    logic [NUM_BANKS-1:0]  bank_busy_q;
    logic [NUM_BANKS-1:0]  take;
    logic [DATA_W-1:0]     bank_word [NUM_BANKS];
    logic [DATA_W-1:0]     sel_word;

    mbm_decode #(
        .ADDR_W (ADDR_W),
        .BANK_W (BANK_W)
    ) u_decode (
        .rd   (rd),
        .wr   (wr),
        .addr (addr),
        .kind (kind),
        .bank (bank),
        .row  (row)
    );

    // Acceptance: a well-formed request whose bank has no open window
    always_comb begin
        req_ok = (kind == REQ_READ) || (kind == REQ_WRITE);
        stall  = req_ok && bank_busy_q[bank];
        accept = req_ok && !stall;
        err    = (kind == REQ_BAD);
    end

    // Per-bank timers and storage
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        // Bank steering: this bank takes the accepted request it is addressed by
        always_comb take[b] = accept && (bank == BANK_W'(b));

        mbm_bank_timer #(
            .BANK_CYC (BANK_CYC)
        ) u_timer (
            .clk    (clk),
            .rst_n  (rst_n),
            .take   (take[b]),
            .busy_q (bank_busy_q[b])
        );

        mbm_bank_store #(
            .DATA_W (DATA_W),
            .ROW_W  (ROW_W)
        ) u_store (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (take[b] && (kind == REQ_WRITE)),
            .row   (row),
            .wdata (wdata),
            .rword (bank_word[b])
        );
    end

    // Busy export: open windows plus the bank accepting in this cycle
    always_comb busy = bank_busy_q | take;

    // Read selection: word from the addressed bank
    always_comb sel_word = bank_word[bank];

    mbm_rd_pipe #(
        .DATA_W (DATA_W),
        .RD_LAT (RD_LAT)
    ) u_rd_pipe (
        .clk    (clk),
        .rst_n  (rst_n),
        .launch (accept && (kind == REQ_READ)),
        .din    (sel_word),
        .dout   (rdata)
    );

endmodule

// File: rtl/mbm_four_bank_chk.sv
// Module: mbm_four_bank_chk
// Port-level checker for mbm_four_bank; attached by bind below.
// Assumes: reset is held at least two cycles at start.
module mbm_four_bank_chk #(
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 16,
    parameter int NUM_BANKS = 4,
    parameter int RD_LAT    = 2,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [ADDR_W-1:0]    addr,
    input logic [DATA_W-1:0]    wdata,
    input logic                 rd,
    input logic                 wr,
    input logic [DATA_W-1:0]    rdata,
    input logic                 stall,
    input logic [NUM_BANKS-1:0] busy,
    input logic                 err
);

    logic              rd_acc;
    logic [RD_LAT-1:0] acc_sr;

    // Read acceptance seen at the ports
    always_comb rd_acc = rd && !wr && !addr[0] && !stall;

    // Shadow of accepted reads, one bit per cycle of latency
    always_ff @(posedge clk) begin
        if (!rst_n) acc_sr <= '0;
        else        acc_sr <= {acc_sr[RD_LAT-2:0], rd_acc};
    end

    p_rdata_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata != '0) |-> acc_sr[RD_LAT-1]);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd && !wr) |-> (!stall && !err));

    p_stall_on_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (busy[addr[BANK_W:1]] && (rd != wr)));

    p_err_no_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !stall);

    p_one_new_bank_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(busy & ~$past(busy)) <= 1);

    for (genvar n = 0; n < NUM_BANKS; n++) begin : g_hold
        p_busy_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(busy[n]) |=> busy[n]);
    end

endmodule

bind mbm_four_bank mbm_four_bank_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .NUM_BANKS (NUM_BANKS),
    .RD_LAT    (RD_LAT)
) u_chk (.*);

// File: tb/test_mbm_four_bank.sv
// Scoreboard bench: the driver predicts stall, err, busy and read data from its
// own bank and storage model; the monitor compares read data as it emerges.
module test_mbm_four_bank;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 10;
    localparam int DW = 16;
    localparam int NB = 4;
    localparam int BC = 4;
    localparam int RL = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
    logic          rd, wr;
    logic [DW-1:0] rdata;
    logic          stall, err;
    logic [NB-1:0] busy;

    mbm_four_bank #(
        .ADDR_W(AW), .DATA_W(DW), .NUM_BANKS(NB), .BANK_CYC(BC), .RD_LAT(RL)
    ) i_mbm_four_bank (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .rd(rd), .wr(wr),
        .rdata(rdata), .stall(stall), .busy(busy), .err(err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    typedef struct {
        int          due;
        logic [15:0] val;
        int          adr;
    } exp_t;
    exp_t sbq[$];

    logic [DW-1:0] shadow [int];
    int bfree [NB];

    function automatic logic [DW-1:0] mread(int w);
        return shadow.exists(w) ? shadow[w] : '0;
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    // Driver: present one request, check the combinational flags, predict effects
    task automatic drive(bit r, bit w, int a, logic [DW-1:0] d);
        int  k, b, wi;
        bit  bad, es;
        logic [NB-1:0] eb;
        @(negedge clk);
        a     = a & ((1 << AW) - 1);
        rd    = r; wr = w; addr = a[AW-1:0]; wdata = d;
        #1;
        k   = cyc;
        b   = (a >> 1) % NB;
        wi  = a >> 1;
        bad = (r && w) || ((r || w) && a[0]);
        es  = (r || w) && !bad && (k < bfree[b]);
        check(err == bad, (r && w) ? "R8" : "R9", "err flag", err, bad);
        check(stall == es, "R6/R7", "stall flag", stall, es);
        if ((r || w) && !bad && !es) begin
            bfree[b] = k + BC;
            if (w) shadow[wi] = d;
            else   sbq.push_back('{k + RL, mread(wi), a});
        end
        for (int i = 0; i < NB; i++) eb[i] = (k < bfree[i]);
        check(busy == eb, "R5/R2", "busy vector", busy, eb);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) drive(1'b0, 1'b0, 0, '0);
    endtask

    // Monitor: compare emerging read data against the scoreboard head
    exp_t e;
    always @(negedge clk) begin
        #3;
        if (rst_n && !done) begin
            if (sbq.size() > 0 && sbq[0].due <= cyc) begin
                e = sbq.pop_front();
                check(e.due == cyc, "R3", "read latency", cyc, e.due);
                check(rdata == e.val, "R4", $sformatf("read data @%0h", e.adr), rdata, e.val);
            end else if (rdata != '0) begin
                check(1'b0, "R3", "rdata outside data cycle", rdata, 0);
            end
        end
    end

    initial begin
        bit [31:0] s;
        int a;
        bit r, w;
        rd = 0; wr = 0; addr = '0; wdata = '0;
        for (int i = 0; i < NB; i++) bfree[i] = 0;
        repeat (3) @(posedge clk);
        // R1: outputs are quiet in reset
        #1;
        check(rdata == '0 && busy == '0 && stall == 0 && err == 0, "R1", "outputs in reset",
              {rdata, busy, stall, err}, 0);
        @(negedge clk) rst_n = 1'b1;
        #1;
        check(rdata == '0 && busy == '0 && stall == 0 && err == 0, "R1", "outputs after reset",
              {rdata, busy, stall, err}, 0);
        // R1: unwritten word reads zero
        drive(1, 0, 'h40, '0);
        idle(3);
        // R7: back-to-back writes over consecutive words, one per bank
        drive(0, 1, 'h00, 16'hA000);
        drive(0, 1, 'h02, 16'hA001);
        drive(0, 1, 'h04, 16'hA002);
        drive(0, 1, 'h06, 16'hA003);
        // R4: read them back as soon as each bank frees
        drive(1, 0, 'h00, '0);
        drive(1, 0, 'h02, '0);
        drive(1, 0, 'h04, '0);
        drive(1, 0, 'h06, '0);
        idle(4);
        // R5: probe bank 1 in every cycle of its window
        drive(0, 1, 'h0A, 16'hB0B0);
        drive(1, 0, 'h12, '0);
        drive(1, 0, 'h12, '0);
        drive(1, 0, 'h12, '0);
        drive(1, 0, 'h0A, '0);
        idle(4);
        // R6: a write refused by stall leaves storage untouched
        drive(0, 1, 'h20, 16'h1111);
        drive(0, 1, 'h28, 16'h2222);
        idle(4);
        drive(1, 0, 'h28, '0);
        idle(4);
        // R8: both strobes, ignored
        drive(1, 1, 'h30, 16'h5555);
        idle(1);
        drive(1, 0, 'h30, '0);
        idle(4);
        // R9: odd write and odd read, ignored
        drive(0, 1, 'h33, 16'h6666);
        drive(1, 0, 'h35, '0);
        idle(1);
        drive(1, 0, 'h32, '0);
        idle(4);
        // Mixed pseudo-random traffic over the small address space
        s = 32'h1234_5678;
        for (int i = 0; i < 400; i++) begin
            s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
            a = int'(s[AW-1:0]);
            if (s[20:18] != 3'd0) a = a & ~1;
            r = s[22];
            w = !s[22] || (s[27:24] == 4'd0);
            if (s[30:29] == 2'd0) begin r = 0; w = 0; end
            drive(r, w, a, s[DW+8:9]);
        end
        idle(6);
        check(sbq.size() == 0, "R3", "reads left undelivered", sbq.size(), 0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL R1-watchdog: actual hung run expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule